// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

This block is one pulse-width-modulation timer channel. A programmable prescaler and a power-of-two divider turn the input clock into count ticks. A 16-bit down-counter uses those ticks to form a waveform whose period comes from a period register and whose high time comes from a compare register. The counter runs either edge-aligned (down to zero, then reload) or center-aligned (down to zero, then back up to the period). It can reload automatically or stop after a single period.

Software programs the channel through a simple write port with a 2-bit register select. New period and compare values are held in pending registers and reach the counter only at the next cycle boundary. The channel raises a period flag and a duty flag. Software clears each flag by writing 1 to it, and either flag can drive the interrupt line when its enable bit is set. The live counter value is always visible on an output.

Top module: `pwm_timer_channel`

## Requirements
- R1: The tick rate is the clock divided by (prescale+1) times a divisor picked by the 3-bit divider select. The encodings are 000=2, 001=4, 010=8, 011=16 and 100=1; other codes divide by 1. The control word (select 0) carries these fields: enable bit 0, auto-reload bit 1, center-aligned bit 2, period-flag-at-top bit 3, period interrupt enable bit 4, duty interrupt enable bit 5, divider select bits 8:6 and prescale bits 16:9.
- R2: In edge-aligned mode the counter starts at the period value and steps down by one per tick. After reaching 0 it reloads. `pwm_out` is high while the channel is enabled and the counter is at or below the active compare value. It is low while the channel is disabled.
- R3: Writes to the period register (select 1) and the compare register (select 2) take effect only at the next cycle boundary or at the next enable.
- R4: A period value of 0 keeps `pwm_out` high while the channel is enabled.
- R5: Any write that changes the auto-reload bit clears both the pending period and the pending compare registers.
- R6: In center-aligned mode the counter runs from the period down to 0 and then up to the period. The tick that finds it at the period starts the next cycle, reloading the counter and turning it downward.
- R7: In center-aligned mode, the period flag sets on the underflow step when bit 3 is 0, and on the step at the top when bit 3 is 1. In edge-aligned mode bit 3 has no effect and the flag sets on every reload step.
- R8: The duty flag sets when a downward step lands on the compare value. In edge-aligned mode with compare equal to period, it never sets.
- R9: Writing 1 to bit 0 (period) or bit 1 (duty) of the flag register (select 3) clears that flag. A hardware set in the same cycle as a clear wins. `irq` is high when a set flag has its enable bit set.
- R10: In center-aligned mode a period value of 0xFFFF is loaded as 0xFFFE. Edge-aligned mode loads it unchanged.
- R11: While enable is low the counter holds its value. A rising enable loads the counter from the pending period. In one-shot mode the counter halts at the end of the first period.
- R12: After reset the counter, the output, both flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 compare, 3 flags |
| wr_data | input | 17 | Write data |
| count | output | 16 | Live counter value |
| pwm_out | output | 1 | PWM waveform |
| period_flag | output | 1 | Period event flag |
| duty_flag | output | 1 | Duty event flag |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: the counter's reload step, which sets the period flag, and a software write that clears that flag. The bench waits for the negedge at which the counter reads 0. It then drives the write-1-to-clear at once, so the write is sampled on the very edge where the counter reloads. After that edge the flag must still read 1. A later clear written on an edge with no event must then drop it. The bench also lines up a period write with the reload edge and checks that the old period is reused for one more cycle.

// File: rtl/pwm_pkg.sv
// Package: shared constants for the PWM timer channel.
// Holds the register selects, the bit layout of the control word and the
// divider-select decode. Assumes a divider of at most 16.
package pwm_pkg;
    localparam int          DIV_SEL_W   = 3;
    localparam int          MAX_DIV_LOG = 4;

    localparam logic [1:0]  ADDR_CTRL    = 2'd0;
    localparam logic [1:0]  ADDR_PERIOD  = 2'd1;
    localparam logic [1:0]  ADDR_COMPARE = 2'd2;
    localparam logic [1:0]  ADDR_FLAGS   = 2'd3;

    localparam int BIT_EN   = 0;
    localparam int BIT_AR   = 1;
    localparam int BIT_CTR  = 2;
    localparam int BIT_TOP  = 3;
    localparam int BIT_PIE  = 4;
    localparam int BIT_DIE  = 5;
    localparam int SEL_LSB  = 6;
    localparam int PRE_LSB  = SEL_LSB + DIV_SEL_W;
    localparam int FLAG_P   = 0;
    localparam int FLAG_D   = 1;

    typedef struct packed {
        logic                 en;
        logic                 auto_reload;
        logic                 center;
        logic                 top_src;
        logic                 pie;
        logic                 die;
        logic [DIV_SEL_W-1:0] div_sel;
    } ctrl_t;

    // Terminal value of the divider counter (divisor minus one) for a select code.
    function automatic logic [MAX_DIV_LOG-1:0] div_terminal(input logic [DIV_SEL_W-1:0] s);
        case (s)
            3'b000:  return 4'd1;
            3'b001:  return 4'd3;
            3'b010:  return 4'd7;
            3'b011:  return 4'd15;
            default: return 4'd0;
        endcase
    endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
// Module: pwm_tick_gen
// Builds the count tick from the clock. A prescaler divides by (prescale+1),
// then a power-of-two divider picked by div_sel divides further. Both counters
// are held at zero while run is low, so every start begins at a fresh phase.
// Assumes prescale and div_sel may change at any time; >= compares recover.
module pwm_tick_gen
    import pwm_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [PRE_W-1:0]     prescale,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 tick
);
    localparam int DCW = MAX_DIV_LOG;

    logic [PRE_W-1:0] pre_cnt;
    logic [DCW-1:0]   div_cnt;
    logic [DCW-1:0]   div_term;
    logic             pre_hit;
    logic             div_hit;

    // Terminal compares for both stages and the resulting tick.
    always_comb begin
        div_term = div_terminal(div_sel);
        pre_hit  = (pre_cnt >= prescale);
        div_hit  = (div_cnt >= div_term);
        tick     = run && pre_hit && div_hit;
    end

    // Advance the prescaler every clock and the divider on each prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R1: with a nonzero prescale, two ticks never fall on adjacent cycles.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && prescale != '0) |=> (!tick || prescale == '0));
endmodule

// File: rtl/pwm_core.sv
// Module: pwm_core
// The counter, the active (shadowed) period and compare, and the waveform.
// On a rising enable it loads the pending values. On each tick it steps in
// edge- or center-aligned fashion. At a cycle boundary it reloads the pending
// values, or halts in one-shot mode. It emits one-cycle period and duty event
// pulses. Assumes a tick pulse is at most one cycle long.
module pwm_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             auto_reload,
    input  logic             center,
    input  logic             top_src,
    input  logic [CNT_W-1:0] per_pend,
    input  logic [CNT_W-1:0] cmp_pend,
    output logic [CNT_W-1:0] count,
    output logic             pwm_out,
    output logic             period_evt,
    output logic             duty_evt
);
    localparam logic [CNT_W-1:0] CMAX  = '1;
    localparam logic [CNT_W-1:0] CZERO = '0;
    localparam logic [CNT_W-1:0] CONE  = CNT_W'(1);

    logic [CNT_W-1:0] act_per, act_cmp, cnt_n, per_load;
    logic             dir_up, dir_n, running, run_n, en_d;
    logic             start, step, boundary;

    // Next-state decode for one tick, covering both alignment modes.
    always_comb begin
        per_load   = (center && per_pend == CMAX) ? (CMAX - CONE) : per_pend;
        start      = en && !en_d;
        step       = tick && running && en && !start;
        cnt_n      = count;
        dir_n      = dir_up;
        run_n      = running && en;
        boundary   = 1'b0;
        period_evt = 1'b0;
        duty_evt   = 1'b0;
        if (step) begin
            if (!center) begin
                if (count == CZERO) begin
                    boundary   = 1'b1;
                    period_evt = 1'b1;
                end else begin
                    cnt_n    = count - CONE;
                    duty_evt = (cnt_n == act_cmp);
                end
            end else if (!dir_up) begin
                if (count == CZERO) begin
                    period_evt = !top_src || (act_per == CZERO);
                    if (act_per == CZERO) begin
                        boundary = 1'b1;
                    end else begin
                        dir_n = 1'b1;
                        cnt_n = CONE;
                    end
                end else begin
                    cnt_n    = count - CONE;
                    duty_evt = (cnt_n == act_cmp);
                end
            end else begin
                if (count >= act_per) begin
                    boundary   = 1'b1;
                    period_evt = top_src;
                end else begin
                    cnt_n = count + CONE;
                end
            end
            if (boundary) begin
                if (auto_reload) begin
                    cnt_n = per_load;
                    dir_n = 1'b0;
                end else begin
                    run_n = 1'b0;
                end
            end
        end
    end

    // Counter, direction, run state and shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count   <= '0;
            act_per <= '0;
            act_cmp <= '0;
            dir_up  <= 1'b0;
            running <= 1'b0;
            en_d    <= 1'b0;
        end else begin
            en_d <= en;
            if (start) begin
                count   <= per_load;
                act_per <= per_load;
                act_cmp <= cmp_pend;
                dir_up  <= 1'b0;
                running <= 1'b1;
            end else begin
                count   <= cnt_n;
                dir_up  <= dir_n;
                running <= run_n;
                if (boundary && auto_reload) begin
                    act_per <= per_load;
                    act_cmp <= cmp_pend;
                end
            end
        end
    end

    // Waveform: high at or below the compare value while enabled.
    always_comb pwm_out = en && (count <= act_cmp);

    // R11: a disabled channel holds its count.
    p_hold_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));
    // R2: a running counter never exceeds its active period.
    p_within_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count <= act_per));
    // R10: a center-aligned start never loads the all-ones period.
    p_no_ffff_center_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && center) |=> (act_per != CMAX));
    // R8: a duty event leaves the counter on the compare value.
    p_duty_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        duty_evt |=> (count == act_cmp));
endmodule

// File: rtl/pwm_timer_channel.sv
// Module: pwm_timer_channel (top)
// Register file for one PWM channel: control word, pending period and
// compare, and the write-1-to-clear event flags. It also wires up the tick
// generator and the counter core. Assumes one register write per cycle. A
// change of the auto-reload bit clears the pending period and compare.
module pwm_timer_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 8,
    parameter int DATA_W = (CNT_W > PRE_LSB + PRE_W) ? CNT_W : PRE_LSB + PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  count,
    output logic              pwm_out,
    output logic              period_flag,
    output logic              duty_flag,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [PRE_W-1:0] prescale;
    logic [CNT_W-1:0] per_pend, cmp_pend;
    logic             wr_ctrl, wr_per, wr_cmp, wr_flags, mode_flip;
    logic             tick, period_evt, duty_evt;

    // Write decode and detection of a change in the auto-reload bit.
    always_comb begin
        wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
        wr_per    = wr_en && (wr_addr == ADDR_PERIOD);
        wr_cmp    = wr_en && (wr_addr == ADDR_COMPARE);
        wr_flags  = wr_en && (wr_addr == ADDR_FLAGS);
        mode_flip = wr_ctrl && (wr_data[BIT_AR] != ctrl.auto_reload);
    end

    // Control word and prescale registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            prescale <= '0;
        end else if (wr_ctrl) begin
            ctrl.en          <= wr_data[BIT_EN];
            ctrl.auto_reload <= wr_data[BIT_AR];
            ctrl.center      <= wr_data[BIT_CTR];
            ctrl.top_src     <= wr_data[BIT_TOP];
            ctrl.pie         <= wr_data[BIT_PIE];
            ctrl.die         <= wr_data[BIT_DIE];
            ctrl.div_sel     <= wr_data[SEL_LSB +: DIV_SEL_W];
            prescale         <= wr_data[PRE_LSB +: PRE_W];
        end
    end

    // Pending period and compare, cleared on a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_flip) begin
            per_pend <= '0;
            cmp_pend <= '0;
        end else begin
            if (wr_per) per_pend <= wr_data[CNT_W-1:0];
            if (wr_cmp) cmp_pend <= wr_data[CNT_W-1:0];
        end
    end

    // Event flags: a hardware set outranks a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_flag <= 1'b0;
            duty_flag   <= 1'b0;
        end else begin
            period_flag <= period_evt || (period_flag && !(wr_flags && wr_data[FLAG_P]));
            duty_flag   <= duty_evt   || (duty_flag   && !(wr_flags && wr_data[FLAG_D]));
        end
    end

    // Interrupt request from enabled flags.
    always_comb irq = (period_flag && ctrl.pie) || (duty_flag && ctrl.die);

    pwm_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.en),
        .prescale (prescale),
        .div_sel  (ctrl.div_sel),
        .tick     (tick)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctrl.en),
        .tick        (tick),
        .auto_reload (ctrl.auto_reload),
        .center      (ctrl.center),
        .top_src     (ctrl.top_src),
        .per_pend    (per_pend),
        .cmp_pend    (cmp_pend),
        .count       (count),
        .pwm_out     (pwm_out),
        .period_evt  (period_evt),
        .duty_evt    (duty_evt)
    );

    // R5: a change of the auto-reload bit empties both pending registers.
    p_mode_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flip |=> (per_pend == '0 && cmp_pend == '0));
    // R9: a period event always leaves the flag set.
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |=> period_flag);
    // R9: without a clear write, a set flag stays set.
    p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (period_flag && !(wr_flags && wr_data[FLAG_P])) |=> period_flag);
endmodule

// File: tb/tb_pwm_timer_channel.sv
// Bench for pwm_timer_channel. A table of divider settings is walked by one
// loop, then directed tests cover modes, flags and corner cases. Inputs change
// on negedges and outputs are sampled on negedges.
module tb_pwm_timer_channel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [16:0] wr_data;
    logic [15:0] count;
    logic        pwm_out, period_flag, duty_flag, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_timer_channel dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .pwm_out(pwm_out), .period_flag(period_flag),
        .duty_flag(duty_flag), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  pre;
        logic [2:0]  sel;
        logic [15:0] gap;
    } div_vec_t;

    localparam div_vec_t DIV_TAB [5] = '{
        '{8'd0,   3'd4, 16'd1},
        '{8'd0,   3'd0, 16'd2},
        '{8'd2,   3'd1, 16'd12},
        '{8'd4,   3'd3, 16'd80},
        '{8'd255, 3'd2, 16'd2048}
    };

    function automatic logic [16:0] cfg(input bit en, input bit ar, input bit ctr,
                                        input bit top, input bit pie, input bit die,
                                        input logic [2:0] sel, input logic [7:0] pre);
        return {pre, sel, die, pie, top, ctr, ar, en};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Caller stands at a negedge; the write is sampled on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [16:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R11 watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        int n;
        logic [15:0] prev, held;
        int eseq [8]  = '{3, 2, 1, 0, 3, 2, 1, 0};
        int cseq [12] = '{3, 2, 1, 0, 1, 2, 3, 3, 2, 1, 0, 1};

        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        chk("R12 count", count, 0);
        chk("R12 pwm_out", pwm_out, 0);
        chk("R12 period_flag", period_flag, 0);
        chk("R12 duty_flag", duty_flag, 0);
        chk("R12 irq", irq, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: walk the divider table and measure the gap between count steps.
        for (int k = 0; k < 5; k++) begin
            wr(2'd0, cfg(0, 1, 0, 0, 0, 0, DIV_TAB[k].sel, DIV_TAB[k].pre));
            wr(2'd1, 17'd200);
            wr(2'd0, cfg(1, 1, 0, 0, 0, 0, DIV_TAB[k].sel, DIV_TAB[k].pre));
            @(negedge clk);
            prev = count;
            while (count == prev) @(negedge clk);
            prev = count;
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (count == prev);
            chk("R1 tick gap", n, DIV_TAB[k].gap);
        end

        // R2/R7/R8/R9: edge-aligned, period 3, compare 1, at-top select set (ignored).
        wr(2'd0, cfg(0, 1, 0, 1, 1, 0, 3'd4, 8'd0));
        wr(2'd1, 17'd3);
        wr(2'd2, 17'd1);
        wr(2'd3, 17'd3);
        wr(2'd0, cfg(1, 1, 0, 1, 1, 0, 3'd4, 8'd0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R2 edge count", count, eseq[i]);
            chk("R2 edge pwm_out", pwm_out, (eseq[i] <= 1) ? 1 : 0);
            if (i == 2) begin
                chk("R8 duty on down-landing", duty_flag, 1);
                chk("R9 irq masked duty", irq, 0);
            end
            if (i == 3) chk("R7 no flag before reload", period_flag, 0);
            if (i == 4) begin
                chk("R7 edge flag on reload", period_flag, 1);
                chk("R9 irq from period", irq, 1);
            end
        end

        // R3: period write lands on the reload edge; old period is reused once.
        wr(2'd1, 17'd5);
        chk("R3 old period kept", count, 3);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R3 reached zero", count, 0);
        @(negedge clk);
        chk("R3 new period loaded", count, 5);

        // R9: clear on a quiet edge.
        wr(2'd3, 17'd1);
        chk("R9 period cleared", period_flag, 0);
        chk("R9 duty untouched", duty_flag, 1);

        // R9: clear on the reload edge -> set wins.
        while (count != 16'd0) @(negedge clk);
        wr(2'd3, 17'd1);
        chk("R9 set wins over clear", period_flag, 1);
        wr(2'd3, 17'd3);
        chk("R9 both cleared period", period_flag, 0);
        chk("R9 both cleared duty", duty_flag, 0);

        // R8: compare equal to period in edge mode never sets duty.
        wr(2'd0, cfg(0, 1, 0, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd1, 17'd2);
        wr(2'd2, 17'd2);
        wr(2'd3, 17'd3);
        wr(2'd0, cfg(1, 1, 0, 0, 0, 0, 3'd4, 8'd0));
        repeat (10) @(negedge clk);
        chk("R8 no duty when cmp==per", duty_flag, 0);
        chk("R8 period still fires", period_flag, 1);

        // R6/R7: center-aligned, underflow source.
        wr(2'd0, cfg(0, 1, 1, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd1, 17'd3);
        wr(2'd2, 17'd1);
        wr(2'd3, 17'd3);
        wr(2'd0, cfg(1, 1, 1, 0, 0, 0, 3'd4, 8'd0));
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk("R6 center count", count, cseq[i]);
            chk("R6 center pwm_out", pwm_out, (cseq[i] <= 1) ? 1 : 0);
            if (i == 2) chk("R8 center duty", duty_flag, 1);
            if (i == 3) chk("R7 underflow not yet", period_flag, 0);
            if (i == 4) chk("R7 underflow source", period_flag, 1);
        end

        // R7: center-aligned, at-top source.
        wr(2'd0, cfg(0, 1, 1, 1, 0, 0, 3'd4, 8'd0));
        wr(2'd3, 17'd3);
        wr(2'd0, cfg(1, 1, 1, 1, 0, 0, 3'd4, 8'd0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 4) chk("R7 underflow ignored", period_flag, 0);
            if (i == 6) chk("R7 top not yet", period_flag, 0);
            if (i == 7) chk("R7 top source", period_flag, 1);
        end

        // R10: 0xFFFF clamps in center mode only.
        wr(2'd0, cfg(0, 1, 1, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd1, 17'hFFFF);
        wr(2'd0, cfg(1, 1, 1, 0, 0, 0, 3'd4, 8'd0));
        @(negedge clk);
        chk("R10 center clamp", count, 16'hFFFE);

        // R11/R2: disable holds the count and drives the output low.
        wr(2'd0, cfg(0, 1, 1, 0, 0, 0, 3'd4, 8'd0));
        held = count;
        repeat (4) @(negedge clk);
        chk("R11 count held", count, held);
        chk("R2 out low when off", pwm_out, 0);
        wr(2'd0, cfg(1, 1, 0, 0, 0, 0, 3'd4, 8'd0));
        @(negedge clk);
        chk("R10 edge no clamp", count, 16'hFFFF);
        wr(2'd0, cfg(0, 1, 0, 0, 0, 0, 3'd4, 8'd0));

        // R11: one-shot halts after one period (mode change clears first).
        wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd1, 17'd2);
        wr(2'd2, 17'd0);
        wr(2'd3, 17'd3);
        wr(2'd0, cfg(1, 0, 0, 0, 0, 0, 3'd4, 8'd0));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R11 one-shot count", count, (i < 3) ? 2 - i : 0);
            if (i == 3) chk("R11 one-shot end flag", period_flag, 1);
        end

        // R5/R4: mode change empties period -> output high with period 0.
        wr(2'd0, cfg(0, 0, 0, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd1, 17'd6);
        wr(2'd2, 17'd1);
        wr(2'd0, cfg(0, 1, 0, 0, 0, 0, 3'd4, 8'd0));
        wr(2'd0, cfg(1, 1, 0, 0, 0, 0, 3'd4, 8'd0));
        repeat (3) @(negedge clk);
        chk("R5 period cleared", count, 0);
        chk("R4 zero period high", pwm_out, 1);
        repeat (3) @(negedge clk);
        chk("R4 stays high", pwm_out, 1);

        finish_up();
    end
endmodule